// File: doc/BRIEF.md
# Clock-Controlled LFSR Cascade Keystream Generator

This block produces a pseudo-random bit stream from a chain of equal-length linear feedback shift registers. Each stage in the chain is stepped only when the stage before it currently presents a 1 at its output. The first stage steps on every enabled cycle. The output bit of the final stage is the keystream bit. A deep chain of short primitive stages gives a very long combined period, (2^L-1)^M for M stages of length L.

Every stage decides whether to step from the values its neighbours held before the clock edge. All stages then update together on the single clock edge, so there are no derived or rippled clocks. A parallel load writes one seed into every stage at once. A seed of zero would lock a stage, so it is replaced by the value 1. A per-stage step vector shows which stages will advance at the coming edge, so the gating can be observed from outside.

Top module: `cascade_keystream`

## Requirements
- R1: While `rst` is high at a clock edge, every stage is set to the value 1. On the cycle after reset, `key_o` is 1.
- R2: When `load_i` is high, every stage k takes `seed_i[k*WIDTH +: WIDTH]` at the edge. Stage 0 sits in the least significant slice. `load_i` takes priority over `en_i`, and `step_o` is all zero on a load cycle.
- R3: A seed slice equal to zero is stored as the value 1.
- R4: On a cycle with `en_i` high and `load_i` low, stage 0 steps, and `step_o[0]` is 1.
- R5: On a cycle with `en_i` high and `load_i` low, `step_o[i]` for i ≥ 1 equals bit 0 of stage i-1's current state. A stage advances at the edge exactly when its `step_o` bit is 1.
- R6: A stepping stage with state s becomes {^(s & TAP_MASK), s[WIDTH-1:1]}. The default is WIDTH = 7 with TAP_MASK = 7'h03, a primitive feedback with a stage period of 127. A stage that does not step holds its value.
- R7: `key_o` is bit 0 of the last stage's state. It changes only across an edge where the last stage steps or a load occurs.
- R8: With `en_i` low and `load_i` low, `step_o` is zero and no stage changes.
- R9: A single stage that is stepped on every cycle repeats its output with period 127. Each period contains 64 ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Advance the chain this cycle |
| load_i | input | 1 | Write all stage seeds this cycle |
| seed_i | input | STAGES*WIDTH | Packed seeds, stage 0 in the low slice |
| key_o | output | 1 | Keystream bit (last stage output) |
| step_o | output | STAGES | Per-stage step indication for the coming edge |

## Verification
The bench builds two copies of the block. The first uses the default 15 stages of 7 bits, which exercises gating decisions deep down the chain under random enables, loads and zero seeds. The second is built with a single stage, where the keystream is that stage's own output. That makes the 127-cycle period and its balance of ones directly observable; a long chain would hide them behind a period far beyond any run.

// File: rtl/ccg_pkg.sv
`timescale 1ns/1ps
package ccg_pkg;

    // Per-cycle action applied to the whole chain
    typedef enum logic [1:0] {
        ACT_HOLD = 2'd0,
        ACT_LOAD = 2'd1,
        ACT_STEP = 2'd2
    } chain_act_e;

    localparam int              DEF_STAGES = 15;
    localparam int              DEF_WIDTH  = 7;
    localparam logic [DEF_WIDTH-1:0] DEF_TAPS = 7'h03;

endpackage

// File: rtl/ccg_stage.sv
`timescale 1ns/1ps
module ccg_stage #(
    parameter int               WIDTH    = 7,
    parameter logic [WIDTH-1:0] TAP_MASK = 7'h03
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [WIDTH-1:0] seed_i,
    input  logic             step_i,
    output logic             out_o
);

    localparam logic [WIDTH-1:0] UNIT = WIDTH'(1);

    logic [WIDTH-1:0] state_q;
    logic [WIDTH-1:0] state_next;
    logic [WIDTH-1:0] seed_fixed;
    logic             feedback;

    // Feedback from the tapped bits, inserted at the top after a right shift
    always_comb begin
        feedback   = ^(state_q & TAP_MASK);
        state_next = {feedback, state_q[WIDTH-1:1]};
        seed_fixed = (seed_i == '0) ? UNIT : seed_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UNIT;
        end else if (load_i) begin
            state_q <= seed_fixed;
        end else if (step_i) begin
            state_q <= state_next;
        end
    end

    assign out_o = state_q[0];

endmodule

// File: rtl/ccg_gate.sv
`timescale 1ns/1ps
module ccg_gate
    import ccg_pkg::*;
#(
    parameter int STAGES = 15
) (
    input  chain_act_e        act_i,
    input  logic [STAGES-1:0] lead_i,
    output logic [STAGES-1:0] step_o
);

    // lead_i[k] is the pre-edge output of stage k-1 (constant 1 for stage 0)
    always_comb begin
        unique case (act_i)
            ACT_STEP: step_o = lead_i;
            ACT_LOAD: step_o = '0;
            ACT_HOLD: step_o = '0;
            default:  step_o = '0;
        endcase
    end

endmodule

// File: rtl/cascade_keystream.sv
`timescale 1ns/1ps
module cascade_keystream
    import ccg_pkg::*;
#(
    parameter int               STAGES   = DEF_STAGES,
    parameter int               WIDTH    = DEF_WIDTH,
    parameter logic [WIDTH-1:0] TAP_MASK = DEF_TAPS
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      en_i,
    input  logic                      load_i,
    input  logic [STAGES*WIDTH-1:0]   seed_i,
    output logic                      key_o,
    output logic [STAGES-1:0]         step_o
);

    localparam int SEED_BITS = STAGES * WIDTH;

    chain_act_e        act;
    logic [STAGES-1:0] stage_out;
    logic [STAGES-1:0] lead;

    // Load wins over enable
    always_comb begin
        if (load_i) begin
            act = ACT_LOAD;
        end else if (en_i) begin
            act = ACT_STEP;
        end else begin
            act = ACT_HOLD;
        end
    end

    generate
        if (STAGES == 1) begin : g_single
            assign lead = 1'b1;
        end else begin : g_chain
            assign lead = {stage_out[STAGES-2:0], 1'b1};
        end
    endgenerate

    ccg_gate #(
        .STAGES (STAGES)
    ) gate_i (
        .act_i  (act),
        .lead_i (lead),
        .step_o (step_o)
    );

    generate
        for (genvar k = 0; k < STAGES; k++) begin : g_stage
            ccg_stage #(
                .WIDTH    (WIDTH),
                .TAP_MASK (TAP_MASK)
            ) stage_i (
                .clk    (clk),
                .rst    (rst),
                .load_i (load_i),
                .seed_i (seed_i[k*WIDTH +: WIDTH]),
                .step_i (step_o[k]),
                .out_o  (stage_out[k])
            );
        end
    endgenerate

    assign key_o = stage_out[STAGES-1];

    // SEED_BITS documents the packed seed width for integrators
    if (SEED_BITS < 1) begin : g_bad_width
        $error("cascade_keystream: seed width must be positive");
    end

endmodule

// File: rtl/cascade_keystream_chk.sv
`timescale 1ns/1ps
module cascade_keystream_chk #(
    parameter int STAGES = 15,
    parameter int WIDTH  = 7
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en_i,
    input logic                    load_i,
    input logic [STAGES*WIDTH-1:0] seed_i,
    input logic                    key_o,
    input logic [STAGES-1:0]       step_o
);

    assert_reset_key_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> key_o);

    assert_load_no_step_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (step_o == '0));

    assert_zero_seed_R3: assert property (@(posedge clk) disable iff (rst)
        (load_i && (seed_i[STAGES*WIDTH-1 -: WIDTH] == '0)) |=> key_o);

    assert_head_steps_R4: assert property (@(posedge clk) disable iff (rst)
        (en_i && !load_i) |-> step_o[0]);

    assert_key_stable_R7: assert property (@(posedge clk) disable iff (rst)
        (!step_o[STAGES-1] && !load_i) |=> $stable(key_o));

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !load_i) |-> (step_o == '0));

endmodule

bind cascade_keystream cascade_keystream_chk #(
    .STAGES (STAGES),
    .WIDTH  (WIDTH)
) chk_i (
    .clk    (clk),
    .rst    (rst),
    .en_i   (en_i),
    .load_i (load_i),
    .seed_i (seed_i),
    .key_o  (key_o),
    .step_o (step_o)
);

// File: tb/cascade_keystream_tb_top.sv
`timescale 1ns/1ps
module cascade_keystream_tb_top;

    localparam int             M    = 15;
    localparam int             L    = 7;
    localparam logic [L-1:0]   MASK = 7'h03;
    localparam int             PER  = 127;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst;
    logic             en;
    logic             ld;
    logic [M*L-1:0]   seed;
    logic             key;
    logic [M-1:0]     step;

    logic             en1;
    logic             ld1;
    logic [L-1:0]     seed1;
    logic             key1;
    logic [0:0]       step1;

    int checks = 0;
    int fails  = 0;

    logic [L-1:0] mdl [M];
    logic         rec [2*PER];

    cascade_keystream dut_i (
        .clk (clk), .rst (rst), .en_i (en), .load_i (ld),
        .seed_i (seed), .key_o (key), .step_o (step)
    );

    cascade_keystream #(.STAGES(1)) dut1_i (
        .clk (clk), .rst (rst), .en_i (en1), .load_i (ld1),
        .seed_i (seed1), .key_o (key1), .step_o (step1)
    );

    function automatic logic [L-1:0] adv(input logic [L-1:0] s);
        return {^(s & MASK), s[L-1:1]};
    endfunction

    function automatic logic [M-1:0] exp_step(input logic e, input logic l);
        logic [M-1:0] r;
        r = '0;
        if (e && !l) begin
            r[0] = 1'b1;
            for (int k = 1; k < M; k++) r[k] = mdl[k-1][0];
        end
        return r;
    endfunction

    function automatic logic [M*L-1:0] rand_seed();
        logic [M*L-1:0] s;
        for (int k = 0; k < M; k++) begin
            s[k*L +: L] = L'($urandom);
            if (($urandom % 8) == 0) s[k*L +: L] = '0;
        end
        return s;
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check step before the edge, key after it
    task automatic cyc(input logic e, input logic l, input logic [M*L-1:0] s,
                       input bit use_dir, input logic [M-1:0] dir, input string req);
        logic [M-1:0] es;
        @(negedge clk);
        en = e; ld = l; seed = s;
        #1;
        es = exp_step(e, l);
        chk(step === es, "R4 R5 step vector", 32'(step), 32'(es));
        if (use_dir) chk(step === dir, req, 32'(step), 32'(dir));
        @(posedge clk);
        for (int k = 0; k < M; k++) begin
            if (l) mdl[k] = (s[k*L +: L] == '0) ? L'(1) : s[k*L +: L];
            else if (es[k]) mdl[k] = adv(mdl[k]);
        end
        #1;
        chk(key === mdl[M-1][0], "R6 R7 key bit", 32'(key), 32'(mdl[M-1][0]));
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [M*L-1:0] s;
        logic [M-1:0]   d;
        int             ones;
        bit             same;
        void'($urandom(32'h5EED_0042));
        rst = 1'b1; en = 1'b0; ld = 1'b0; seed = '0;
        en1 = 1'b0; ld1 = 1'b0; seed1 = '0;
        for (int k = 0; k < M; k++) mdl[k] = L'(1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk(key === 1'b1, "R1 key after reset", 32'(key), 32'd1);
        chk(step === '0, "R1 R8 no step after reset", 32'(step), 32'd0);

        // R1: from the reset state every stage is 1, so all stages step
        cyc(1'b1, 1'b0, '0, 1'b1, {M{1'b1}}, "R1 R5 reset state steps all");

        // R3: all-zero seeds become 1, so every stage steps next cycle
        cyc(1'b0, 1'b1, '0, 1'b0, '0, "R3 load zero");
        cyc(1'b1, 1'b0, '0, 1'b1, {M{1'b1}}, "R3 R5 zero seeds forced to 1");

        // R2: load beats enable, no step on the load cycle
        s = rand_seed();
        cyc(1'b1, 1'b1, s, 1'b1, '0, "R2 load priority");

        // R8: enable low holds everything
        for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, rand_seed(), 1'b1, '0, "R8 idle");

        // R4: every stage output 0, only the head steps
        for (int k = 0; k < M; k++) s[k*L +: L] = L'(2);
        cyc(1'b0, 1'b1, s, 1'b0, '0, "R2 load even");
        d = '0; d[0] = 1'b1;
        cyc(1'b1, 1'b0, '0, 1'b1, d, "R4 only head steps");

        // R5: alternating stage outputs
        for (int k = 0; k < M; k++) s[k*L +: L] = (k % 2 == 0) ? L'(1) : L'(2);
        cyc(1'b0, 1'b1, s, 1'b0, '0, "R2 load alternating");
        d = '0; d[0] = 1'b1;
        for (int k = 1; k < M; k++) d[k] = ((k - 1) % 2 == 0);
        cyc(1'b1, 1'b0, '0, 1'b1, d, "R5 alternating gate");

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic e, l;
            e = (($urandom % 4) != 0);
            l = (($urandom % 50) == 0);
            cyc(e, l, rand_seed(), 1'b0, '0, "rand");
        end

        // R9: single stage period and balance
        @(negedge clk);
        en = 1'b0; ld = 1'b0;
        ld1 = 1'b1; seed1 = 7'h55;
        @(negedge clk);
        ld1 = 1'b0; en1 = 1'b1;
        for (int i = 0; i < 2*PER; i++) begin
            #1;
            rec[i] = key1;
            @(negedge clk);
        end
        en1 = 1'b0;
        same = 1'b1;
        ones = 0;
        for (int i = 0; i < PER; i++) begin
            if (rec[i] !== rec[i+PER]) same = 1'b0;
            if (rec[i] === 1'b1) ones++;
        end
        chk(same, "R9 period 127 repeat", 32'(same), 32'd1);
        chk(ones == 64, "R9 ones per period", 32'(ones), 32'd64);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule